// File: doc/BRIEF.md
# Byte, Halfword and Bit Reversal Unit

This block rearranges a 64-bit operand according to a 4-bit operation code. It covers byte swaps inside every halfword, byte reversal inside each 32-bit word or across the whole doubleword, and halfword swaps inside each word or across the doubleword. It also reverses the bits inside every byte, reverses the bits of a full word or doubleword, and sign-extends a byte or a halfword.

Every operation that produces only a 32-bit result copies bit 31 of that result into the upper 32 bits. The permutation logic itself is combinational. A single register stage with a clock enable captures the result, so a result appears one cycle after its operation is presented. An operation code outside the defined set gives a zero result and raises an illegal flag.

Top module: `brx_unit`

## Requirements
- R1: While reset is asserted, and directly after it, `res_valid`, `illegal` and `result` are all zero.
- R2: `res_valid` equals the value `op_valid` had one clock earlier. The result and the flag for a request appear one cycle after it. While `op_valid` is low, `result` and `illegal` keep their values.
- R3: Code 0 exchanges the two bytes of each halfword in the low 32 bits of the operand and sign-extends bit 31 of that result. The upper 32 bits of the operand have no effect.
- R4: Code 1 exchanges the two bytes of each of the four halfwords.
- R5: Code 2 reverses the byte order inside each 32-bit word separately. Code 3 reverses the order of all eight bytes.
- R6: Code 4 exchanges the two halfwords inside each 32-bit word. Code 5 reverses the order of all four halfwords.
- R7: Code 6 reverses the bit order inside each byte of the low 32 bits and sign-extends bit 31 of the result. The upper 32 bits of the operand have no effect. Code 7 reverses the bits inside each of the eight bytes.
- R8: Code 8 reverses the order of the low 32 bits and sign-extends bit 31 of the result. Code 9 reverses the order of all 64 bits.
- R9: Code 10 copies bit 7 of the operand into bits 63..8. Code 11 copies bit 15 into bits 63..16.
- R10: Codes 12 to 15 give a zero result with `illegal` set to 1. Every defined code gives `illegal` set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe and register enable |
| op_sel | input | 4 | Operation code |
| operand | input | 64 | Source value |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Permuted value |
| illegal | output | 1 | Set for an undefined operation code |

## Verification
The only internal state is the output register and its enable. A wrong captured value therefore shows at `result` one cycle after the request. An enable fault shows as a result that changes while `op_valid` is low, which the hold checks catch in the very next cycle. Faults in the permutation network show as misplaced bytes, halfwords or bits. The asymmetric operands (distinct values in every byte, and single set bits near the lane edges) make each such fault visible on the first operation that routes through the broken path. Faults in the sign-extension paths are exposed by operands whose 32-bit result has bit 31 both set and clear.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int DW = 64;
  localparam int WW = 32;
  localparam int SELW = 4;

  typedef enum logic [SELW-1:0] {
    OP_SWB_H32  = 4'd0,
    OP_SWB_H64  = 4'd1,
    OP_REVB_W   = 4'd2,
    OP_REVB_D   = 4'd3,
    OP_SWH_W    = 4'd4,
    OP_REVH_D   = 4'd5,
    OP_BREV_B32 = 4'd6,
    OP_BREV_B64 = 4'd7,
    OP_BREV_W32 = 4'd8,
    OP_BREV_D   = 4'd9,
    OP_SEXT_B   = 4'd10,
    OP_SEXT_H   = 4'd11
  } op_e;

  function automatic logic [DW-1:0] sx_word(input logic [WW-1:0] w);
    return {{(DW-WW){w[WW-1]}}, w};
  endfunction
endpackage

// File: rtl/brx_lane_perm.sv
module brx_lane_perm #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] swb_h,
  output logic [DW-1:0] revb_w,
  output logic [DW-1:0] revb_d,
  output logic [DW-1:0] swh_w,
  output logic [DW-1:0] revh_d
);
  localparam int NB   = DW / 8;
  localparam int NH   = DW / 16;
  localparam int NW   = DW / 32;
  localparam int HALF = DW / 2;

  logic [DW-1:0] msk_lo_byte;
  logic [DW-1:0] msk_lo_half;

  for (genvar h = 0; h < NH; h++) begin : g_mb
    assign msk_lo_byte[16*h +: 16] = 16'h00FF;
  end

  for (genvar w = 0; w < NW; w++) begin : g_mh
    assign msk_lo_half[32*w +: 32] = 32'h0000FFFF;
  end

  for (genvar b = 0; b < NB; b++) begin : g_rb
    assign revb_d[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end

  assign swb_h  = ((din >> 8) & msk_lo_byte) | ((din & msk_lo_byte) << 8);
  assign revb_w = {revb_d[HALF-1:0], revb_d[DW-1:HALF]};
  assign swh_w  = ((din >> 16) & msk_lo_half) | ((din & msk_lo_half) << 16);
  assign revh_d = {swh_w[HALF-1:0], swh_w[DW-1:HALF]};
endmodule

// File: rtl/brx_bit_perm.sv
module brx_bit_perm #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] brev_b,
  output logic [DW-1:0] brev_d
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign brev_b[8*b + i] = din[8*b + 7 - i];
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_full
    assign brev_d[i] = din[DW-1-i];
  end
endmodule

// File: rtl/brx_unit.sv
module brx_unit
  import brx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [SELW-1:0] op_sel,
  input  logic [DW-1:0]   operand,
  output logic            res_valid,
  output logic [DW-1:0]   result,
  output logic            illegal
);
  logic [DW-1:0] swb_h, revb_w, revb_d, swh_w, revh_d;
  logic [DW-1:0] brev_b, brev_d;
  logic [DW-1:0] res_d;
  logic          ill_d;
  logic [DW-1:0] res_q;
  logic          ill_q;
  logic          vld_q;

  brx_lane_perm #(.DW(DW)) u_lane (
    .din    (operand),
    .swb_h  (swb_h),
    .revb_w (revb_w),
    .revb_d (revb_d),
    .swh_w  (swh_w),
    .revh_d (revh_d)
  );

  brx_bit_perm #(.DW(DW)) u_bits (
    .din    (operand),
    .brev_b (brev_b),
    .brev_d (brev_d)
  );

  always_comb begin
    ill_d = 1'b0;
    res_d = '0;
    case (op_sel)
      OP_SWB_H32:  res_d = sx_word(swb_h[WW-1:0]);
      OP_SWB_H64:  res_d = swb_h;
      OP_REVB_W:   res_d = revb_w;
      OP_REVB_D:   res_d = revb_d;
      OP_SWH_W:    res_d = swh_w;
      OP_REVH_D:   res_d = revh_d;
      OP_BREV_B32: res_d = sx_word(brev_b[WW-1:0]);
      OP_BREV_B64: res_d = brev_b;
      OP_BREV_W32: res_d = sx_word(brev_d[DW-1 -: WW]);
      OP_BREV_D:   res_d = brev_d;
      OP_SEXT_B:   res_d = {{(DW-8){operand[7]}}, operand[7:0]};
      OP_SEXT_H:   res_d = {{(DW-16){operand[15]}}, operand[15:0]};
      default: begin
        res_d = '0;
        ill_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= op_valid;
      if (op_valid) begin
        res_q <= res_d;
        ill_q <= ill_d;
      end
    end
  end

  assign res_valid = vld_q;
  assign result    = res_q;
  assign illegal   = ill_q;

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_valid == $past(op_valid)));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(result) && $stable(illegal)));

  assert_word_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 4'd0 || op_sel == 4'd6 || op_sel == 4'd8))
      |=> (result[DW-1:WW] == {(DW-WW){result[WW-1]}}));

  assert_byte_sext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd10) |=> (result[DW-1:8] == {(DW-8){result[7]}}));

  assert_bad_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel >= 4'd12) |=> (illegal && result == '0));

  assert_good_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel < 4'd12) |=> !illegal);
endmodule

// File: tb/brx_unit_tb.sv
module brx_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic [63:0] operand;
  logic        res_valid;
  logic [63:0] result;
  logic        illegal;

  int total = 0;
  int bad = 0;
  bit done = 0;

  brx_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .operand(operand), .res_valid(res_valid), .result(result), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] sx32(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [63:0] model(input logic [3:0] s, input logic [63:0] x);
    logic [63:0] o;
    o = '0;
    case (s)
      4'd0: begin
        for (int k = 0; k < 4; k++) o[8*k +: 8] = x[8*(k^1) +: 8];
        o = sx32(o[31:0]);
      end
      4'd1: for (int k = 0; k < 8; k++) o[8*k +: 8] = x[8*(k^1) +: 8];
      4'd2: for (int k = 0; k < 8; k++) o[8*k +: 8] = x[8*((k & 4) | (3 - (k & 3))) +: 8];
      4'd3: for (int k = 0; k < 8; k++) o[8*k +: 8] = x[8*(7-k) +: 8];
      4'd4: for (int j = 0; j < 4; j++) o[16*j +: 16] = x[16*(j^1) +: 16];
      4'd5: for (int j = 0; j < 4; j++) o[16*j +: 16] = x[16*(3-j) +: 16];
      4'd6: begin
        for (int i = 0; i < 32; i++) o[i] = x[(i & ~7) | (7 - (i & 7))];
        o = sx32(o[31:0]);
      end
      4'd7: for (int i = 0; i < 64; i++) o[i] = x[(i & ~7) | (7 - (i & 7))];
      4'd8: begin
        for (int i = 0; i < 32; i++) o[i] = x[31-i];
        o = sx32(o[31:0]);
      end
      4'd9:  for (int i = 0; i < 64; i++) o[i] = x[63-i];
      4'd10: o = {{56{x[7]}}, x[7:0]};
      4'd11: o = {{48{x[15]}}, x[15:0]};
      default: o = '0;
    endcase
    return o;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] s, input logic [63:0] x);
    @(negedge clk);
    op_valid = 1'b1;
    op_sel   = s;
    operand  = x;
    @(negedge clk);
    op_valid = 1'b0;
    check(req, result, model(s, x));
    check({req, " illegal R10"}, {63'd0, illegal}, {63'd0, (s >= 4'd12)});
    check({req, " valid R2"}, {63'd0, res_valid}, 64'd1);
  endtask

  task automatic t_reset;
    check("R1 result", result, 64'd0);
    check("R1 valid", {63'd0, res_valid}, 64'd0);
    check("R1 illegal", {63'd0, illegal}, 64'd0);
  endtask

  task automatic t_halfword_bytes;
    run_op("R3", 4'd0, 64'h0123_4567_89AB_CDEF);
    run_op("R3", 4'd0, 64'hFFFF_FFFF_7F00_0012);
    check("R3 upper ignored", result, model(4'd0, 64'h0000_0000_7F00_0012));
    run_op("R4", 4'd1, 64'h0123_4567_89AB_CDEF);
    run_op("R4", 4'd1, 64'h8000_0001_0080_FF00);
  endtask

  task automatic t_word_bytes;
    run_op("R5 word", 4'd2, 64'h0123_4567_89AB_CDEF);
    run_op("R5 dword", 4'd3, 64'h0123_4567_89AB_CDEF);
    run_op("R5 dword", 4'd3, 64'h0000_0000_0000_0080);
  endtask

  task automatic t_halves;
    run_op("R6 word", 4'd4, 64'h0123_4567_89AB_CDEF);
    run_op("R6 dword", 4'd5, 64'h0123_4567_89AB_CDEF);
    run_op("R6 dword", 4'd5, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_bitrev;
    run_op("R7 b32", 4'd6, 64'h0000_0000_0000_0001);
    run_op("R7 b32", 4'd6, 64'hDEAD_BEEF_0100_0000);
    check("R7 upper ignored", result, 64'hFFFF_FFFF_8000_0000);
    run_op("R7 b64", 4'd7, 64'h0123_4567_89AB_CDEF);
    run_op("R8 w32", 4'd8, 64'h1234_5678_0000_0001);
    check("R8 sign", result, 64'hFFFF_FFFF_8000_0000);
    run_op("R8 w32", 4'd8, 64'h0000_0000_8000_0000);
    run_op("R8 d", 4'd9, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_sext;
    run_op("R9 byte", 4'd10, 64'h1234_5678_9ABC_DE80);
    run_op("R9 byte", 4'd10, 64'hFFFF_FFFF_FFFF_FF7F);
    run_op("R9 half", 4'd11, 64'h0000_0000_0000_8001);
    run_op("R9 half", 4'd11, 64'hFFFF_FFFF_FFFF_7FFF);
  endtask

  task automatic t_illegal;
    for (int c = 12; c < 16; c++) begin
      run_op("R10", 4'(c), 64'hA5A5_5A5A_C3C3_3C3C);
      check("R10 zero", result, 64'd0);
    end
  endtask

  task automatic t_hold;
    logic [63:0] prev;
    run_op("R2 seed", 4'd3, 64'h1122_3344_5566_7788);
    prev = result;
    @(negedge clk);
    op_valid = 1'b0;
    op_sel   = 4'd15;
    operand  = 64'hFFFF_0000_FFFF_0000;
    @(negedge clk);
    check("R2 hold result", result, prev);
    check("R2 hold illegal", {63'd0, illegal}, 64'd0);
    check("R2 valid low", {63'd0, res_valid}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    op_valid = 1'b0;
    op_sel = '0;
    operand = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halfword_bytes();
    t_word_bytes();
    t_halves();
    t_bitrev();
    t_sext();
    t_illegal();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < WATCHDOG; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule